// File: doc/BRIEF.md
# PCI INTx to PIRQ Route Table

This block keeps a small byte-addressed register window of interrupt-route words, one for each PCI device number from 25 to 31. It also answers a combinational query that maps a device number and one of its four INTx pins to one of eight PIRQ lines, numbered 0 to 7. Firmware programs the route words through a simple read/write port. The port is little-endian, takes a byte address, and moves 1, 2 or 4 bytes per access. The interrupt fabric puts the slot and pin on the lookup port and gets back the PIRQ index.

Each route word holds four 4-bit fields, one for each pin. The PIRQ index is taken from the low three bits of the field. Device 30 has no writable route: its word always reads zero, and its pins go to PIRQ 4 to 7. A device number that has no route word uses a rotating default that only reaches the upper four PIRQs. An access that would run past the end of the window is cut short. An address that lies beyond the window wraps back into it.

Top module: `pirq_route_table`

## Requirements
- R1: Reset sets the route words of devices 25 to 29 and 31 to 0x3210, which routes INTA..INTD to PIRQ 0..3. Every other byte of the window reads zero after reset.
- R2: For devices 25 to 29 and 31, the lookup returns bits [2:0] of the field that starts at bit 4*pin of that device's route word. Pin codes are INTA=0, INTB=1, INTC=2, INTD=3.
- R3: The route word of device 30 always reads zero and ignores writes. A lookup of slot 30 returns 4+pin.
- R4: A lookup of any slot outside 25..31 returns ((slot + pin) mod 4) + 4.
- R5: Data is little-endian. Byte k of an access (wdata/rdata bits [8k+7:8k]) belongs to window byte address+k. Byte lanes at or above the access length are ignored on writes and read back as zero.
- R6: Only the low 5 bits of the address select a byte, so the window is 32 bytes and repeats across the address space.
- R7: When the masked address plus the length passes 32, the access stops at byte 31 and does not wrap to byte 0. Lanes past the cut read zero and write nothing.
- R8: A write is visible to the lookup from the first clock edge that accepts it.
- R9: Read data appears on rdata one cycle after rd_en and holds until the next read. Bytes with no register behind them read zero.
- R10: The route word of device d sits at byte offset 4*(d-25), bits [15:0], so it occupies two bytes. The upper two bytes of each 4-byte slot, and bytes 28 to 31, have no register behind them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 16 | Byte address, masked to the window |
| len | input | 3 | Access length in bytes (1, 2 or 4) |
| wdata | input | 32 | Write data, little-endian lanes |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| lk_slot | input | 5 | Lookup device number |
| lk_pin | input | 2 | Lookup INTx pin |
| lk_pirq | output | 3 | PIRQ index for the lookup |

## Verification
The bound checker watches several behaviours on every cycle:
- the fixed mapping of slot 30 and the upper-half result for slots below 25;
- that reads aimed at the device-30 word or at the last window byte return zero in the expected lanes;
- that writes landing above the implemented bytes leave every route word untouched;
- that rdata holds between reads.

Only the bench's scenarios can show the rest:
- the exact reset image;
- the little-endian placement of partial writes;
- address wrap through the mask;
- that a clamped write near the window end does not wrap onto device 25;
- that a reprogrammed route changes the lookup one edge later.

// File: rtl/pirq_route_table.sv
module pirq_route_table #(
  parameter int ADDR_W        = 16,
  parameter int WIN_BYTES     = 32,
  parameter int FIRST_DEV     = 25,
  parameter int NUM_DEV       = 7,
  parameter int FIXED_DEV     = 30,
  parameter int FIELD_W       = 4,
  parameter logic [15:0] DEFAULT_ROUTE = 16'h3210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        len,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [4:0]        lk_slot,
  input  logic [1:0]        lk_pin,
  output logic [2:0]        lk_pirq
);
  localparam int WIN_AW     = $clog2(WIN_BYTES);
  localparam int WORD_W     = 4 * FIELD_W;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int STRIDE     = 4;
  localparam int FIXED_IDX  = FIXED_DEV - FIRST_DEV;
  localparam int IDX_W      = $clog2(NUM_DEV);

  logic [WORD_W-1:0] route_q [NUM_DEV];
  logic [7:0]        win_b   [WIN_BYTES];

  logic [WIN_AW-1:0] base;
  logic [WIN_AW:0]   span;
  logic [WIN_AW:0]   reach;
  logic              unused_addr_hi;

  assign base           = addr[WIN_AW-1:0];
  assign unused_addr_hi = ^addr[ADDR_W-1:WIN_AW];
  assign reach          = {1'b0, base} + (WIN_AW+1)'(len);
  assign span           = (int'(reach) > WIN_BYTES) ? (WIN_AW+1)'(WIN_BYTES - int'(base))
                                                    : (WIN_AW+1)'(len);

  always_comb begin
    for (int b = 0; b < WIN_BYTES; b++) win_b[b] = '0;
    for (int j = 0; j < NUM_DEV; j++)
      for (int h = 0; h < WORD_BYTES; h++)
        win_b[STRIDE*j + h] = route_q[j][8*h +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_DEV; j++)
        route_q[j] <= (j == FIXED_IDX) ? '0 : WORD_W'(DEFAULT_ROUTE);
    end else if (wr_en) begin
      for (int j = 0; j < NUM_DEV; j++)
        for (int h = 0; h < WORD_BYTES; h++)
          if (j != FIXED_IDX &&
              STRIDE*j + h >= int'(base) &&
              STRIDE*j + h <  int'(base) + int'(span))
            route_q[j][8*h +: 8] <= wdata[8*(STRIDE*j + h - int'(base)) +: 8];
    end
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < 4; i++)
      if (i < int'(span))
        rd_next[8*i +: 8] = win_b[WIN_AW'(int'(base) + i)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  logic             in_regs;
  logic [4:0]       rel;
  logic [IDX_W-1:0] idx;
  logic [1:0]       rot;
  logic [2:0]       field;

  assign in_regs = int'(lk_slot) >= FIRST_DEV && int'(lk_slot) < FIRST_DEV + NUM_DEV;
  assign rel     = lk_slot - 5'(FIRST_DEV);
  assign idx     = in_regs ? rel[IDX_W-1:0] : '0;
  assign field   = route_q[idx][FIELD_W*lk_pin +: 3];
  assign rot     = lk_slot[1:0] + lk_pin;

  assign lk_pirq = (int'(lk_slot) == FIXED_DEV) ? {1'b1, lk_pin} :
                   in_regs                      ? field          :
                                                  {1'b1, rot};
endmodule

module pirq_route_table_chk #(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 32,
  parameter int FIRST_DEV = 25,
  parameter int NUM_DEV   = 7,
  parameter int FIXED_DEV = 30,
  parameter int WORD_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        len,
  input logic [31:0]       rdata,
  input logic [4:0]        lk_slot,
  input logic [1:0]        lk_pin,
  input logic [2:0]        lk_pirq,
  input logic [WORD_W-1:0] route_q [NUM_DEV]
);
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam int STRIDE = 4;

  // R3
  fixed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lk_slot) == FIXED_DEV |-> lk_pirq == 3'(4 + int'(lk_pin)));

  // R4
  legacy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lk_slot) < FIRST_DEV |-> lk_pirq[2]);

  // R3
  fixed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && int'(addr[WIN_AW-1:0]) == STRIDE*(FIXED_DEV-FIRST_DEV) && len <= 3'd4
    |=> rdata == '0);

  // R7
  edge_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && int'(addr[WIN_AW-1:0]) == WIN_BYTES-1 |=> rdata[31:8] == '0);

  // R5
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && len == 3'd1 |=> rdata[31:8] == '0);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R10
  for (genvar j = 0; j < NUM_DEV; j++) begin : g_hi
    high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && int'(addr[WIN_AW-1:0]) >= STRIDE*NUM_DEV |=> $stable(route_q[j]));
  end
endmodule

bind pirq_route_table pirq_route_table_chk #(
  .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .FIRST_DEV(FIRST_DEV),
  .NUM_DEV(NUM_DEV), .FIXED_DEV(FIXED_DEV), .WORD_W(4*FIELD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .len(len), .rdata(rdata), .lk_slot(lk_slot), .lk_pin(lk_pin),
  .lk_pirq(lk_pirq), .route_q(route_q)
);

// File: tb/tb_pirq_route_table.sv
`timescale 1ns/100ps
module tb_pirq_route_table;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [15:0] addr = '0;
  logic [2:0]  len = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pirq_route_table dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .len(len), .wdata(wdata), .rdata(rdata), .lk_slot(lk_slot),
    .lk_pin(lk_pin), .lk_pirq(lk_pirq));

  // {slot, pin, expected pirq} after reset: R1, R2, R3, R4
  localparam logic [9:0] VEC [12] = '{
    {5'd25, 2'd0, 3'd0}, {5'd25, 2'd3, 3'd3}, {5'd27, 2'd1, 3'd1},
    {5'd29, 2'd2, 3'd2}, {5'd31, 2'd3, 3'd3}, {5'd30, 2'd0, 3'd4},
    {5'd30, 2'd3, 3'd7}, {5'd0,  2'd0, 3'd4}, {5'd3,  2'd2, 3'd5},
    {5'd12, 2'd1, 3'd5}, {5'd24, 2'd3, 3'd7}, {5'd1,  2'd3, 3'd4}};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic do_write(logic [15:0] a, logic [2:0] l, logic [31:0] d);
    @(negedge clk) begin wr_en = 1; addr = a; len = l; wdata = d; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic do_read(logic [15:0] a, logic [2:0] l, output logic [31:0] v);
    @(negedge clk) begin rd_en = 1; addr = a; len = l; end
    @(negedge clk) rd_en = 0;
    v = rdata;
  endtask

  task automatic look(logic [4:0] s, logic [1:0] p, output logic [2:0] q);
    lk_slot = s; lk_pin = p;
    #1 q = lk_pirq;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [2:0]  q;
    do_reset();
    check("R1 rdata after reset", rdata, 32'h0);

    for (int i = 0; i < 12; i++) begin
      look(VEC[i][9:5], VEC[i][4:3], q);
      check("R2/R3/R4 vector lookup", 32'(q), 32'(VEC[i][2:0]));
    end

    do_read(16'd0, 3'd4, v);  check("R1 R10 dev25 word", v, 32'h0000_3210);
    do_read(16'd24, 3'd2, v); check("R1 dev31 word", v, 32'h3210);
    do_read(16'd20, 3'd2, v); check("R3 dev30 reads zero", v, 32'h0);
    do_read(16'd2, 3'd2, v);  check("R9 R10 unimplemented bytes", v, 32'h0);

    do_write(16'd4, 3'd2, 32'hDEAD_7654);
    for (int p = 0; p < 4; p++) begin
      look(5'd26, 2'(p), q);
      check("R8 R2 new route", 32'(q), 32'(4 + p));
    end
    do_read(16'd4, 3'd4, v);  check("R5 word read", v, 32'h0000_7654);

    do_write(16'd5, 3'd1, 32'hFFFF_FFA1);
    do_read(16'd4, 3'd2, v);  check("R5 byte write lane", v, 32'hA154);
    look(5'd26, 2'd2, q);     check("R2 field pin2", 32'(q), 32'd1);
    look(5'd26, 2'd3, q);     check("R2 field low bits pin3", 32'(q), 32'd2);
    do_read(16'd5, 3'd1, v);  check("R5 single byte read", v, 32'hA1);
    do_read(16'd3, 3'd2, v);  check("R5 straddle read", v, 32'h5400);

    do_write(16'd20, 3'd4, 32'hFFFF_FFFF);
    do_read(16'd20, 3'd4, v); check("R3 dev30 write ignored", v, 32'h0);
    look(5'd30, 2'd1, q);     check("R3 dev30 fixed pin", 32'(q), 32'd5);

    do_write(16'h0040, 3'd2, 32'h0000_5555);
    look(5'd25, 2'd3, q);     check("R6 masked write", 32'(q), 32'd5);
    do_read(16'h1000, 3'd2, v); check("R6 masked read", v, 32'h5555);

    do_write(16'd30, 3'd4, 32'hFFFF_FFFF);
    do_read(16'd0, 3'd2, v);  check("R7 no wrap on write", v, 32'h5555);
    do_read(16'd31, 3'd4, v); check("R7 clamped read", v, 32'h0);
    do_read(16'd31, 3'd4, v); check("R7 second clamped read", v, 32'h0);
    do_write(16'd24, 3'd4, 32'h0000_0765);
    do_read(16'd24, 3'd4, v); check("R10 dev31 at offset 24", v, 32'h0765);

    look(5'd7, 2'd3, q);      check("R4 rotate 7+3", 32'(q), 32'd6);

    @(negedge clk) begin rd_en = 1; addr = 16'd4; len = 3'd2; end
    @(negedge clk) begin rd_en = 0; addr = 16'd0; end
    @(negedge clk) check("R9 rdata held", rdata, 32'hA154);

    do_reset();
    do_read(16'd4, 3'd2, v);  check("R1 re-reset default", v, 32'h3210);
    look(5'd26, 2'd3, q);     check("R1 R2 default lookup", 32'(q), 32'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule